// File: doc/BRIEF.md
# I2C Register Target with Stuck-Bus Timeout

This block is the serial front end of a small register bank. It listens on an I2C bus as a target with a fixed 7-bit address. Through an internal pointer it gives access to a register bank that sits outside the block. The controller can do three things. It can write one register, naming the register in the second byte and the value in the third. It can load only the pointer, by stopping after the register byte. It can read one byte from the register the pointer already selects. The bank supplies read data combinationally at `ptr_o` and takes a one-cycle write strobe.

Both bus lines are sampled on the system clock after two synchroniser flops. SDA is driven open-drain, through an output-enable: when asserted, the line is pulled low. An active-low enable input keeps the whole interface idle while it is high. Two watchdog counters protect the bus. One resets the interface when SCL stays low too long. The other resets the interface when the block itself has held SDA low too long, which lets the line go.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_oe_o` is 0, `wr_en_o` is 0 and `ptr_o` is 0.
- R2: The first byte after a START is taken MSB first: seven address bits, then the R/W bit (1 = read). When the seven bits equal `TGT_ADDR`, the target pulls SDA low through the whole 9th SCL clock.
- R3: A write transaction is address byte with R/W=0, register byte, data byte. All three bytes are acknowledged. `wr_en_o` pulses for exactly one cycle, with `ptr_o` equal to the register byte and `wr_data_o` equal to the data byte.
- R4: A transaction that ends with STOP after the acknowledged register byte loads `ptr_o` with that byte and produces no write strobe.
- R5: After an address byte with R/W=1, the target shifts out `rd_data_i` for the current pointer, MSB first. It changes SDA only while SCL is low. It releases SDA for the 9th clock and after it.
- R6: When the address does not match, the target never asserts `sda_oe_o` for the rest of that transaction, and no write occurs.
- R7: While `en_n_i` is 1, the target is idle: no acknowledge, no write, and `sda_oe_o` is 0 one cycle later.
- R8: If synchronised SCL stays low for `TIMEOUT_CYC` cycles, the interface returns to idle. Bytes clocked afterwards without a new START are not acknowledged and do not change `ptr_o`.
- R9: If the target has asserted `sda_oe_o` for `TIMEOUT_CYC` consecutive cycles, the interface returns to idle and `sda_oe_o` falls on the next cycle.
- R10: A START (SDA falling while SCL is high) in any state restarts address reception. A STOP (SDA rising while SCL is high) returns the interface to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n_i | input | 1 | Active-low interface enable |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ptr_o | output | PTR_W | Register pointer; also the write address |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_data_o | output | 8 | Data written to register `ptr_o` |
| rd_data_i | input | 8 | Bank contents at `ptr_o` |

## Verification
The assertions assume that the bus lines change slowly compared with the system clock. Each SCL phase must last several clock cycles, so that the synchronisers and the edge registers see every level. They also assume that the controller moves SDA only while SCL is low, except to make a START or a STOP. The bench drives SCL with ten-cycle half periods and sets SDA one phase before each rising edge. It holds lines still far beyond the reduced timeout only in the two scenarios that test the watchdogs. The register bank in the bench returns data combinationally from the pointer, as the read path expects.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BITCNT_W = 4;

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;

  // Shift each line one stage deeper every cycle.
  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  // Idle bus level is high, so reset every stage to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  // SDA edges only count as START/STOP while SCL is high in both samples.
  assign start_det = sda_prev_q & ~sda_s & scl_s & scl_prev_q;
  assign stop_det  = ~sda_prev_q & sda_s & scl_s & scl_prev_q;

  assert_start_stop_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise}));

endmodule

// File: rtl/i2c_tgt_watchdog.sv
module i2c_tgt_watchdog #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expire
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_lim;

  assign at_lim = (cnt_q == LIM);

  // Count while the watched condition holds, saturate at the limit, clear otherwise.
  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (!at_lim) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = at_lim;

  assert_clear_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !expire);

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR = 7'h48,
  parameter int unsigned PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              abort,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);

  localparam logic [BITCNT_W-1:0] FULL_BYTE = BITCNT_W'(BYTE_W);

  tgt_state_e          state_q, state_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic [BITCNT_W-1:0] cnt_q, cnt_d;
  logic                oe_q, oe_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic                wr_en_q, wr_en_d;
  logic [BYTE_W-1:0]   wr_data_q, wr_data_d;
  logic                byte_done;
  logic                addr_hit;

  assign byte_done = scl_fall && (cnt_q == FULL_BYTE);
  assign addr_hit  = (sh_q[BYTE_W-1:1] == TGT_ADDR);

  always_comb begin
    state_d   = state_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    oe_d      = oe_q;
    ptr_d     = ptr_q;
    wr_en_d   = 1'b0;
    wr_data_d = wr_data_q;

    if (en_n || abort) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_d = ST_ADDR_ACK;
                oe_d    = 1'b1;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_REG) begin
              state_d = ST_REG_ACK;
              oe_d    = 1'b1;
              ptr_d   = sh_q[PTR_W-1:0];
            end else begin
              state_d   = ST_DATA_ACK;
              oe_d      = 1'b1;
              wr_en_d   = 1'b1;
              wr_data_d = sh_q;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (sh_q[0]) begin
              state_d = ST_RD;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
            end else begin
              state_d = ST_REG;
              oe_d    = 1'b0;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            state_d = ST_DATA;
            oe_d    = 1'b0;
            cnt_d   = '0;
          end
        end
        ST_DATA_ACK: begin
          if (scl_fall) begin
            state_d = ST_IGNORE;
            oe_d    = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            state_d = ST_RD_ACK;
            oe_d    = 1'b0;
            cnt_d   = '0;
          end else if (scl_fall) begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b0};
            oe_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) begin
            state_d = ST_IGNORE;
          end
        end
        ST_IDLE, ST_IGNORE: begin
          oe_d = 1'b0;
        end
        default: begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      oe_q      <= 1'b0;
      ptr_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      state_q   <= state_d;
      sh_q      <= sh_d;
      cnt_q     <= cnt_d;
      oe_q      <= oe_d;
      ptr_q     <= ptr_d;
      wr_en_q   <= wr_en_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr     = ptr_q;
  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q);

  assert_no_write_on_pointer_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REG_ACK) |-> !wr_en_q);

  assert_ignore_keeps_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q);

  assert_disable_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !oe_q);

  assert_abort_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state_q == ST_IDLE));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h48,
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  input  logic [7:0]       rd_data_i
);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic scl_expire, sda_expire, abort;
  logic sda_oe;

  i2c_tgt_linesync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  // Watchdog on the clock line: SCL held low by anyone.
  i2c_tgt_watchdog #(
    .LIMIT(TIMEOUT_CYC)
  ) u_wd_scl (
    .clk   (clk),
    .rst_n (rst_n),
    .active(~scl_s),
    .expire(scl_expire)
  );

  // Watchdog on our own data pull-down.
  i2c_tgt_watchdog #(
    .LIMIT(TIMEOUT_CYC)
  ) u_wd_sda (
    .clk   (clk),
    .rst_n (rst_n),
    .active(sda_oe),
    .expire(sda_expire)
  );

  assign abort = scl_expire | sda_expire;

  i2c_tgt_fsm #(
    .TGT_ADDR(TGT_ADDR),
    .PTR_W   (PTR_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_n     (en_n_i),
    .abort    (abort),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data_i),
    .sda_oe   (sda_oe),
    .ptr      (ptr_o),
    .wr_en    (wr_en_o),
    .wr_data  (wr_data_o)
  );

  assign sda_oe_o = sda_oe;

  assert_sda_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_expire |=> !sda_oe_o);

  assert_write_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> sda_oe_o);

endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

  localparam int H       = 10;
  localparam int TMO     = 300;
  localparam logic [7:0] AW = 8'h90;
  localparam logic [7:0] AR = 8'h91;

  logic       clk;
  logic       rst_n;
  logic       en_n;
  logic       scl_m;
  logic       sda_m;
  logic       sda_bus;
  logic       sda_oe;
  logic [7:0] ptr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] bank [256];

  int checks;
  int fails;
  int wr_cnt;
  int oe_cycles;
  bit done;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = bank[ptr];

  i2c_reg_target #(
    .TGT_ADDR   (7'h48),
    .PTR_W      (8),
    .SYNC_STAGES(2),
    .TIMEOUT_CYC(TMO)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_n_i   (en_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .ptr_o    (ptr),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .rd_data_i(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // External register bank model and activity counters.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bank[i] <= 8'h00;
      wr_cnt    <= 0;
      oe_cycles <= 0;
    end else begin
      if (wr_en) begin
        bank[ptr] <= wr_data;
        wr_cnt    <= wr_cnt + 1;
      end
      if (sda_oe) oe_cycles <= oe_cycles + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(H);
      scl_m = 1'b1; wclk(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H / 2);
    ack = ~sda_bus;
    wclk(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(H);
      scl_m = 1'b1; wclk(H / 2);
      b[i] = sda_bus;
      wclk(H / 2);
      scl_m = 1'b0;
    end
    sda_m = nack; wclk(H);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(2);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] ra, input logic [7:0] d, output bit [2:0] acks);
    bit a;
    bus_start();
    send_byte(AW, a); acks[2] = a;
    send_byte(ra, a); acks[1] = a;
    send_byte(d, a);  acks[0] = a;
    bus_stop();
  endtask

  task automatic do_ptrset(input logic [7:0] ra, output bit [1:0] acks);
    bit a;
    bus_start();
    send_byte(AW, a); acks[1] = a;
    send_byte(ra, a); acks[0] = a;
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
    chk(ptr == 8'h00, "R1 ptr after reset", ptr, 0);
  endtask

  task automatic t_write();
    bit [2:0] acks;
    int w0;
    w0 = wr_cnt;
    do_write(8'h12, 8'hA5, acks);
    wclk(4);
    chk(acks == 3'b111, "R2 R3 write acks", acks, 7);
    chk(wr_cnt == w0 + 1, "R3 one write strobe", wr_cnt - w0, 1);
    chk(bank[8'h12] == 8'hA5, "R3 bank[12] data", bank[8'h12], 8'hA5);
    chk(ptr == 8'h12, "R3 ptr after write", ptr, 8'h12);
  endtask

  task automatic t_ptrset();
    bit [1:0] acks;
    int w0;
    w0 = wr_cnt;
    do_ptrset(8'h30, acks);
    wclk(4);
    chk(acks == 2'b11, "R4 pointer-set acks", acks, 3);
    chk(ptr == 8'h30, "R4 pointer loaded", ptr, 8'h30);
    chk(wr_cnt == w0, "R4 no write strobe", wr_cnt - w0, 0);
  endtask

  task automatic t_read();
    bit [2:0] acks;
    bit [1:0] pa;
    bit a;
    logic [7:0] b;
    do_write(8'h40, 8'hC3, acks);
    do_ptrset(8'h40, pa);
    bus_start();
    send_byte(AR, a);
    chk(a == 1'b1, "R2 read address ack", a, 1);
    recv_byte(1'b1, b);
    chk(b == 8'hC3, "R5 read data msb first", b, 8'hC3);
    chk(sda_oe == 1'b0, "R5 released after nack", sda_oe, 0);
    bus_stop();
    chk(ptr == 8'h40, "R5 pointer kept by read", ptr, 8'h40);
  endtask

  task automatic t_wrong_addr();
    bit a1, a2, a3;
    int w0, o0;
    w0 = wr_cnt; o0 = oe_cycles;
    bus_start();
    send_byte(8'h42, a1);
    send_byte(8'h55, a2);
    send_byte(8'h77, a3);
    bus_stop();
    wclk(4);
    chk({a1, a2, a3} == 3'b000, "R6 no ack for foreign address", {a1, a2, a3}, 0);
    chk(oe_cycles == o0, "R6 sda never pulled", oe_cycles - o0, 0);
    chk(wr_cnt == w0, "R6 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_disabled();
    bit [2:0] acks;
    int w0;
    w0 = wr_cnt;
    en_n = 1'b1;
    do_write(8'h50, 8'h11, acks);
    wclk(4);
    chk(acks == 3'b000, "R7 no ack while disabled", acks, 0);
    chk(wr_cnt == w0, "R7 no write while disabled", wr_cnt - w0, 0);
    en_n = 1'b0;
    wclk(4);
  endtask

  task automatic t_restart();
    bit a;
    int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte(AW, a);
    send_byte(8'h60, a);
    sda_m = 1'b1; wclk(H);
    bus_start();
    send_byte(AW, a);
    send_byte(8'h61, a);
    send_byte(8'h3C, a);
    bus_stop();
    wclk(4);
    chk(bank[8'h61] == 8'h3C && wr_cnt == w0 + 1, "R10 restart then write", bank[8'h61], 8'h3C);
    chk(bank[8'h60] == 8'h00, "R10 abandoned register untouched", bank[8'h60], 0);
  endtask

  task automatic t_scl_timeout();
    bit a, a2;
    logic [7:0] p0;
    p0 = ptr;
    bus_start();
    send_byte(AW, a);
    chk(a == 1'b1, "R8 address acked before stall", a, 1);
    wclk(TMO + 50);
    send_byte(8'h70, a2);
    chk(a2 == 1'b0, "R8 no ack after scl timeout", a2, 0);
    bus_stop();
    wclk(4);
    chk(ptr == p0, "R8 pointer unchanged after timeout", ptr, p0);
  endtask

  task automatic t_sda_timeout();
    bit [1:0] pa;
    bit a;
    do_ptrset(8'h08, pa);
    bus_start();
    send_byte(AR, a);
    wclk(H);
    chk(sda_oe == 1'b1, "R9 target drives zero bit", sda_oe, 1);
    scl_m = 1'b1;
    wclk(TMO + 50);
    chk(sda_oe == 1'b0, "R9 sda released by timeout", sda_oe, 0);
    scl_m = 1'b0; wclk(H);
    bus_stop();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; en_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    wclk(5);
    t_reset();
    rst_n = 1'b1;
    wclk(5);
    t_write();
    t_ptrset();
    t_read();
    t_wrong_addr();
    t_disabled();
    t_restart();
    t_scl_timeout();
    t_sda_timeout();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule